// File: doc/BRIEF.md
# Indexed-Port Multicart Bank Mapper

This block is a cartridge bank mapper for a small 8-bit console system. The CPU reaches it through two byte ports in the low address range. A write to the selector port holds an 8-bit register number. A later write to the value port loads the register that number names. The block holds one 32 KB program bank, four 3-bit pattern selects, a shared 3-bit high bank and a mirroring flag.

From these registers it drives three outputs. The program bank number is zero-extended. There are eight 1 KB pattern-memory bank numbers, one for each 1 KB window of the pattern space, and there is a nametable mirroring select. The memories and the address muxing that use these numbers are outside the block. The bank numbers are combinational functions of the registers, so each new setting is visible on the cycle after the write edge.

Top module: `idx_bank_mapper`

## Requirements
- R1: A write with `cpu_addr` equal to 0x4100 stores all 8 data bits as the register number. A write to 0x4101 decodes that full 8-bit number, so a number of 8 or more selects nothing, even when its low three bits name a valid register.
- R2: When the register number is 0, 1, 2 or 3, a value-port write loads pattern select 0, 1, 2 or 3 with the data bits [2:0].
- R3: When the register number is 4, a value-port write loads the high bank with the data bits [2:0].
- R4: When the register number is 5, a value-port write loads the program bank with the data bits [2:0]. `prg_bank` then shows that value zero-extended.
- R5: When the register number is 7, a value-port write sets `mirror_horiz` to data bit 1, where 1 means horizontal mirroring and 0 means vertical.
- R6: A value-port write with register number 6, or with any number of 8 or more, leaves every output unchanged.
- R7: Window w (0..7) occupies bits [w*BANK_W +: BANK_W] of `chr_bank`. It carries the bank number high*32 + sel[w/2]*4 + (w mod 4), zero-extended. Windows 0 and 1 use select 0, windows 2 and 3 use select 1, and so on.
- R8: After reset the program bank, the four pattern selects, the high bank, the register number and the mirroring flag are all zero. Window w therefore reads w mod 4, and `prg_bank` reads 0.
- R9: Writes to any address other than 0x4100 and 0x4101 change nothing. Cycles with `cpu_wr` low also change nothing.
- R10: When the parameter NO_CHR_ROM is 1, every bit of `chr_bank` is 0 whatever the register contents. `prg_bank` and `mirror_horiz` behave as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| prg_bank | output | PRG_W (8) | 32 KB program bank number |
| chr_bank | output | 8*BANK_W (64) | Eight 1 KB pattern bank numbers, window 0 in the low bits |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench sweeps every register number from 0 to 9, plus 255. For each number it writes all 256 data values to the value port. This shows that only data bits [2:0] reach a select, and that only bit 1 reaches the mirroring flag. Each window output is compared against the arithmetic bank formula. Because the selects and the high bank are loaded with differing values, a window wired to the wrong select, or given the wrong offset, gives a wrong number. Numbers 6, 8, 9 and 255 separate full-index decoding from decoding of only the low three bits. Writes to neighbouring addresses and to strobe-less cycles show that address decoding is exact. A second instance with pattern ROM disabled shows the forced-zero outputs.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int NUM_SEL = 4;
    localparam int NUM_WIN = 2 * NUM_SEL;
    localparam int OFS_W   = 2;
    localparam int RAW_W   = SEL_W + SEL_W + OFS_W;

    typedef struct packed {
        logic [DATA_W-1:0]               reg_num;
        logic [NUM_SEL-1:0][SEL_W-1:0]   sel;
        logic [SEL_W-1:0]                high;
        logic [SEL_W-1:0]                prg;
        logic                            mirror_h;
    } map_state_t;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'h4100,
    parameter logic [ADDR_W-1:0] VAL_PORT = 16'h4101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output map_state_t        state_q
);
    map_state_t state_d;
    logic hit_sel, hit_val;

    always_comb begin
        hit_sel = wr && (addr == SEL_PORT);
        hit_val = wr && (addr == VAL_PORT);
        state_d = state_q;
        if (hit_sel) begin
            state_d.reg_num = data;
        end else if (hit_val) begin
            case (state_q.reg_num)
                8'd0, 8'd1, 8'd2, 8'd3:
                    state_d.sel[state_q.reg_num[1:0]] = data[SEL_W-1:0];
                8'd4: state_d.high     = data[SEL_W-1:0];
                8'd5: state_d.prg      = data[SEL_W-1:0];
                8'd7: state_d.mirror_h = data[1];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_num_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == SEL_PORT) |=> state_q.reg_num == $past(data));

    assert_ignored_num_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == VAL_PORT && (state_q.reg_num == 8'd6 || state_q.reg_num > 8'd7))
        |=> $stable(state_q));

    assert_no_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == SEL_PORT || addr == VAL_PORT)) |=> $stable(state_q));

    assert_prg_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == VAL_PORT && state_q.reg_num == 8'd5)
        |=> state_q.prg == $past(data[SEL_W-1:0]));

    assert_high_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == VAL_PORT && state_q.reg_num == 8'd4)
        |=> state_q.high == $past(data[SEL_W-1:0]));

    assert_mirror_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == VAL_PORT && state_q.reg_num == 8'd7)
        |=> state_q.mirror_h == $past(data[1]));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);
endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter bit NO_CHR_ROM = 1'b0
) (
    input  logic [NUM_SEL-1:0][SEL_W-1:0] sel,
    input  logic [SEL_W-1:0]              high,
    output logic [NUM_WIN-1:0][BANK_W-1:0] bank
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [OFS_W-1:0] OFS = OFS_W'(w % 4);
        if (NO_CHR_ROM) begin : g_off
            assign bank[w] = '0;
        end else begin : g_on
            logic [RAW_W-1:0] raw;
            assign raw     = {high, sel[w/2], OFS};
            assign bank[w] = BANK_W'(raw);
        end
    end

    if (!NO_CHR_ROM) begin : g_chk
        always_comb begin
            assert_shared_sel_R7: assert (bank[0][BANK_W-1:OFS_W] == bank[1][BANK_W-1:OFS_W]
                                       && bank[6][BANK_W-1:OFS_W] == bank[7][BANK_W-1:OFS_W]);
        end
    end
endmodule

// File: rtl/idx_bank_mapper.sv
module idx_bank_mapper
    import mapper_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int PRG_W      = 8,
    parameter bit NO_CHR_ROM = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_wr,
    input  logic [15:0]               cpu_addr,
    input  logic [7:0]                cpu_data,
    output logic [PRG_W-1:0]          prg_bank,
    output logic [NUM_WIN*BANK_W-1:0] chr_bank,
    output logic                      mirror_horiz
);
    map_state_t                    st_q;
    logic [NUM_WIN-1:0][BANK_W-1:0] win_bank;

    mapper_regs #(.ADDR_W(16)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .addr   (cpu_addr),
        .data   (cpu_data),
        .state_q(st_q)
    );

    mapper_chr_map #(.BANK_W(BANK_W), .NO_CHR_ROM(NO_CHR_ROM)) u_chr (
        .sel (st_q.sel),
        .high(st_q.high),
        .bank(win_bank)
    );

    assign prg_bank     = PRG_W'(st_q.prg);
    assign chr_bank     = win_bank;
    assign mirror_horiz = st_q.mirror_h;

    if (NO_CHR_ROM) begin : g_nochk
        always_comb begin
            assert_no_rom_zero_R10: assert (chr_bank == '0);
        end
    end
endmodule

// File: tb/tb_idx_bank_mapper.sv
module tb_idx_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [7:0]  prg_bank, prg_bank_nc;
    logic [63:0] chr_bank, chr_bank_nc;
    logic        mirror_horiz, mirror_nc;

    int errors = 0;
    int checks = 0;

    logic [7:0] m_num;
    logic [2:0] m_sel [4];
    logic [2:0] m_high, m_prg;
    logic       m_mir;

    always #5 clk = ~clk;

    idx_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .prg_bank(prg_bank), .chr_bank(chr_bank),
        .mirror_horiz(mirror_horiz));

    idx_bank_mapper #(.NO_CHR_ROM(1'b1)) dut_nc (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .prg_bank(prg_bank_nc), .chr_bank(chr_bank_nc),
        .mirror_horiz(mirror_nc));

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    function automatic logic [63:0] exp_chr();
        logic [63:0] v = '0;
        for (int w = 0; w < 8; w++)
            v[w*8 +: 8] = 8'(m_high * 32 + m_sel[w/2] * 4 + (w % 4));
        return v;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (prg_bank !== {5'd0, m_prg}) begin
            errors++;
            $display("FAIL %s prg_bank actual=%h expected=%h", tag, prg_bank, {5'd0, m_prg});
        end
        checks++;
        if (mirror_horiz !== m_mir) begin
            errors++;
            $display("FAIL %s mirror actual=%b expected=%b", tag, mirror_horiz, m_mir);
        end
        checks++;
        if (chr_bank !== exp_chr()) begin
            errors++;
            $display("FAIL %s/R7 chr_bank actual=%h expected=%h", tag, chr_bank, exp_chr());
        end
        checks++;
        if (chr_bank_nc !== 64'd0 || prg_bank_nc !== prg_bank || mirror_nc !== mirror_horiz) begin
            errors++;
            $display("FAIL R10 no-rom instance actual chr=%h prg=%h expected chr=0 prg=%h",
                     chr_bank_nc, prg_bank_nc, prg_bank);
        end
    endtask

    task automatic model_value(input logic [7:0] d);
        case (m_num)
            8'd0, 8'd1, 8'd2, 8'd3: m_sel[m_num[1:0]] = d[2:0];
            8'd4: m_high = d[2:0];
            8'd5: m_prg  = d[2:0];
            8'd7: m_mir  = d[1];
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [7:0] n);
        if (n <= 8'd3) return "R2";
        if (n == 8'd4) return "R3";
        if (n == 8'd5) return "R4";
        if (n == 8'd7) return "R5";
        if (n > 8'd7)  return "R1";
        return "R6";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_num = 0; m_high = 0; m_prg = 0; m_mir = 0;
        for (int i = 0; i < 4; i++) m_sel[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R8 reset");

        // preload distinct selects so window/select wiring is distinguishable (R7)
        for (int i = 0; i < 5; i++) begin
            bus_write(16'h4100, 8'(i)); m_num = 8'(i);
            bus_write(16'h4101, 8'(i + 2)); model_value(8'(i + 2));
        end
        check_all("R7 preload");

        // sweep of register numbers and data values (R1..R6)
        for (int n = 0; n < 11; n++) begin
            logic [7:0] num = (n == 10) ? 8'd255 : 8'(n);
            bus_write(16'h4100, num); m_num = num;
            for (int d = 0; d < 256; d++) begin
                bus_write(16'h4101, 8'(d)); model_value(8'(d));
                check_all(tag_of(num));
            end
        end

        // nonmatching addresses and idle strobe (R9)
        bus_write(16'h4100, 8'd5); m_num = 8'd5;
        foreach (m_sel[i]) ;
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a;
            case (k)
                0: a = 16'h4102; 1: a = 16'h4000; 2: a = 16'hC101;
                3: a = 16'h4103; 4: a = 16'h0101; default: a = 16'h5101;
            endcase
            bus_write(a, 8'h07);
            check_all("R9 addr");
        end
        @(negedge clk);
        cpu_addr = 16'h4101; cpu_data = 8'h06; cpu_wr = 1'b0;
        @(negedge clk);
        check_all("R9 no strobe");
        bus_write(16'h4101, 8'h06); model_value(8'h06);
        check_all("R4 after R9");

        // reset again returns to zero state (R8)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_num = 0; m_high = 0; m_prg = 0; m_mir = 0;
        for (int i = 0; i < 4; i++) m_sel[i] = 0;
        check_all("R8 rereset");
        bus_write(16'h4101, 8'h05); model_value(8'h05);
        check_all("R8 num zero");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule